// File: doc/BRIEF.md
# Serial Flash Configuration Loader

This block brings a device up from an external serial flash. After reset, or after a qualified program request, it clears its image store and drives an active-low initialisation line. It then waits until that line reads high, because outside logic may still be holding it low. At that point it samples the mode pins and reads the image from the flash over a four-wire serial link: chip select, serial clock, MOSI and MISO.

The read begins with a command byte and a 24-bit start address. In fast mode a dummy byte follows the address. The loader then clocks in the image bytes and a trailing 16-bit checksum. Payload bytes go into a small RAM that user logic reads through a registered port. A good checksum raises the done flag. A bad one pulls the initialisation line low again and done stays low.

In both cases the loader then releases the serial pins: chip select goes high and both output enables drop. A program input held low long enough aborts everything and holds the loader idle. When that input is released, a fresh configuration pass starts.

Top module: `cfg_flash_loader`

## Requirements
- R1: From reset or program release, `init_drive_low` is high and the image RAM is written to zero. This lasts max(IMAGE_BYTES, 4) clock cycles, then `init_drive_low` drops. `done` is low and `spi_cs_n` is high during this phase.
- R2: After the clear phase, no read starts while `init_in` is low. `init_in` passes through a two-stage synchroniser, so `spi_cs_n` falls on the third rising clock edge after `init_in` goes high.
- R3: `mode_sel` is captured when the read starts. The value 3'b110 sends opcode 0x0B, the 24-bit START_ADDR and one 8-bit dummy byte of zeros. Any other value sends opcode 0x03 and START_ADDR. All bits go out MSB first.
- R4: `spi_sclk` idles low and each of its high and low phases lasts SCK_HALF_CYC clock cycles. `spi_mosi` changes only when `spi_sclk` falls. `spi_miso` is sampled when `spi_sclk` rises.
- R5: `spi_cs_n` stays low for exactly 2*N*SCK_HALF_CYC+2 cycles. N is the number of command bits (32 for plain read, 40 for fast read) plus (IMAGE_BYTES+2)*8.
- R6: Received payload byte k is stored at RAM address k, MSB first. `rd_data` returns the byte at `rd_addr` one cycle after the address is applied.
- R7: The checksum is CRC-16 with polynomial 0x1021 and seed 0xFFFF, computed MSB first over the payload. If the last 16 received bits equal it, `done` rises on the same edge as `spi_cs_n` rises and then stays high.
- R8: On a checksum mismatch, `init_drive_low` is asserted on the edge where `spi_cs_n` rises. `done` stays low and the loader stays in this state until a restart.
- R9: While `spi_cs_n` is low, both `spi_sclk_oe` and `spi_mosi_oe` are high. Once done or a failure is reached, `spi_cs_n` is high and both enables are low.
- R10: `prog_n` low for at least ceil(PROG_MIN_NS/CLK_PERIOD_NS) synchronised samples forces `done` low, `spi_cs_n` high and `init_drive_low` high for as long as it is held. Releasing it starts a new pass at R1. A shorter low pulse leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a configuration pass |
| prog_n | input | 1 | Active-low program request |
| init_in | input | 1 | Sensed level of the open-drain initialisation line |
| mode_sel | input | 3 | Flash read variant select |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Active-low flash chip select |
| spi_sclk | output | 1 | Serial clock to flash |
| spi_sclk_oe | output | 1 | Output enable for the serial clock pin |
| spi_mosi | output | 1 | Serial command/address to flash |
| spi_mosi_oe | output | 1 | Output enable for the MOSI pin |
| init_drive_low | output | 1 | Pull the initialisation line low when high |
| done | output | 1 | Configuration completed with a good checksum |
| rd_addr | input | $clog2(IMAGE_BYTES) | Image RAM read address |
| rd_data | output | 8 | Image RAM read data, one cycle latency |

## Verification
Every result has a fixed latency, and the bench checks each one on the exact falling clock edge where it is due.

| Result | Due |
|---|---|
| Initialisation line released | max(IMAGE_BYTES,4) edges after reset |
| Chip select falls | third edge after the line reads high |
| Chip select low | exactly 2*N*SCK_HALF_CYC+2 edges, mode-dependent N |
| Done or failure shows | on the same edge where chip select rises |
| RAM data | one edge after the address |

A behavioural flash model in the bench responds to the serial clock and records the command. A per-clock monitor measures serial clock phase lengths and MOSI stability, and compares the chip-select window and the outcome flags against the expected checksum verdict. The program request is only checked well after its qualification window: the outcome is looked at 40 cycles after a long pulse starts and 50 cycles after a short pulse ends.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_CLEAR,
    ST_WAIT,
    ST_XFER,
    ST_DONE,
    ST_FAIL
  } ld_state_e;

  localparam logic [7:0]  OPC_READ      = 8'h03;
  localparam logic [7:0]  OPC_FAST      = 8'h0B;
  localparam logic [2:0]  MODE_FAST     = 3'b110;
  localparam logic [15:0] CRC_POLY      = 16'h1021;
  localparam logic [15:0] CRC_SEED      = 16'hFFFF;
  localparam int          TX_BITS_PLAIN = 32;
  localparam int          TX_BITS_FAST  = 40;

endpackage

// File: rtl/cfg_prog_filter.sv
module cfg_prog_filter #(
  parameter int MIN_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_n,
  output logic hold
);

  localparam int CW = $clog2(MIN_CYC + 1);

  logic          p_meta, p_sync;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_meta <= 1'b1;
      p_sync <= 1'b1;
    end else begin
      p_meta <= prog_n;
      p_sync <= p_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      hold    <= 1'b0;
    end else if (p_sync) begin
      low_cnt <= '0;
      hold    <= 1'b0;
    end else begin
      if (low_cnt != CW'(MIN_CYC)) low_cnt <= low_cnt + 1'b1;
      if (low_cnt == CW'(MIN_CYC - 1)) hold <= 1'b1;
    end
  end

  // R10
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> (low_cnt == CW'(MIN_CYC)));

  // R10
  hold_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> !$past(p_sync));

endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16
  import cfg_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        en,
  input  logic        bit_in,
  output logic [15:0] crc
);

  logic fb;
  assign fb = crc[15] ^ bit_in;

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= CRC_SEED;
    else if (en)      crc <= {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end

  // R7
  crc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clear) |=> $stable(crc));

endmodule

// File: rtl/cfg_spi_engine.sv
module cfg_spi_engine
  import cfg_loader_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int RX_BITS  = 80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        abort,
  input  logic        fast,
  input  logic [23:0] addr,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        rx_valid,
  output logic        rx_bit,
  output logic        fin
);

  localparam int MAX_BITS = TX_BITS_FAST + RX_BITS;
  localparam int BW       = $clog2(MAX_BITS + 1);
  localparam int DVW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic           busy;
  logic [DVW-1:0] div_q;
  logic [BW-1:0]  bit_q, last_q, txlen_q;
  logic [39:0]    tx_q, first_w;
  logic           tick;

  assign tick = (div_q == DVW'(HALF_CYC - 1));

  always_comb begin
    first_w = {(fast ? OPC_FAST : OPC_READ), addr, 8'h00};
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      last_q   <= '0;
      txlen_q  <= '0;
      tx_q     <= '0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
      fin      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      fin      <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        sclk    <= 1'b0;
        div_q   <= '0;
        bit_q   <= '0;
        tx_q    <= first_w;
        mosi    <= first_w[39];
        txlen_q <= fast ? BW'(TX_BITS_FAST) : BW'(TX_BITS_PLAIN);
        last_q  <= fast ? BW'(TX_BITS_FAST + RX_BITS - 1)
                        : BW'(TX_BITS_PLAIN + RX_BITS - 1);
      end else if (busy) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk) begin
            sclk     <= 1'b1;
            rx_valid <= (bit_q >= txlen_q);
            rx_bit   <= miso;
          end else begin
            sclk <= 1'b0;
            if (bit_q == last_q) begin
              busy <= 1'b0;
              fin  <= 1'b1;
              mosi <= 1'b0;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= {tx_q[38:0], 1'b0};
              mosi  <= tx_q[38];
            end
          end
        end
      end
    end
  end

  // R4
  mosi_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

endmodule

// File: rtl/cfg_flash_loader.sv
module cfg_flash_loader
  import cfg_loader_pkg::*;
#(
  parameter int          CLK_PERIOD_NS = 20,
  parameter int          PROG_MIN_NS   = 500,
  parameter int          SCK_HALF_CYC  = 2,
  parameter int          IMAGE_BYTES   = 8,
  parameter logic [23:0] START_ADDR    = 24'h000000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           prog_n,
  input  logic                           init_in,
  input  logic [2:0]                     mode_sel,
  input  logic                           spi_miso,
  output logic                           spi_cs_n,
  output logic                           spi_sclk,
  output logic                           spi_sclk_oe,
  output logic                           spi_mosi,
  output logic                           spi_mosi_oe,
  output logic                           init_drive_low,
  output logic                           done,
  input  logic [$clog2(IMAGE_BYTES)-1:0] rd_addr,
  output logic [7:0]                     rd_data
);

  localparam int PROG_MIN_CYC = (PROG_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int PAY_BITS     = IMAGE_BYTES * 8;
  localparam int RX_BITS      = PAY_BITS + 16;
  localparam int AW           = $clog2(IMAGE_BYTES);
  localparam int CLR_LAST     = (IMAGE_BYTES < 4) ? 3 : IMAGE_BYTES - 1;
  localparam int CW           = $clog2(CLR_LAST + 1);
  localparam int DW           = $clog2(RX_BITS + 1);

  ld_state_e     state_q;
  logic          hold;
  logic          init_m, init_s;
  logic          fast_q, start_q;
  logic          fin, rx_valid, rx_bit;
  logic [15:0]   crc_val, window_q;
  logic [6:0]    byte_q;
  logic [DW-1:0] data_idx_q;
  logic [CW-1:0] clr_idx_q;
  logic          pay_bit, crc_ok;
  logic          we;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata;
  logic [7:0]    mem [IMAGE_BYTES];

  cfg_prog_filter #(.MIN_CYC(PROG_MIN_CYC)) u_filter (
    .clk(clk), .rst(rst), .prog_n(prog_n), .hold(hold)
  );

  cfg_spi_engine #(.HALF_CYC(SCK_HALF_CYC), .RX_BITS(RX_BITS)) u_engine (
    .clk(clk), .rst(rst), .start(start_q), .abort(hold), .fast(fast_q),
    .addr(START_ADDR), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .fin(fin)
  );

  assign pay_bit = (state_q == ST_XFER) && rx_valid && (data_idx_q < DW'(PAY_BITS));
  assign crc_ok  = (window_q == crc_val);

  cfg_crc16 u_crc (
    .clk(clk), .rst(rst), .clear(start_q), .en(pay_bit), .bit_in(rx_bit), .crc(crc_val)
  );

  // init line synchroniser
  always_ff @(posedge clk) begin
    if (rst) begin
      init_m <= 1'b0;
      init_s <= 1'b0;
    end else begin
      init_m <= init_in;
      init_s <= init_m;
    end
  end

  // receive window, byte assembly and bit index
  always_ff @(posedge clk) begin
    if (rst || start_q) begin
      window_q   <= '0;
      byte_q     <= '0;
      data_idx_q <= '0;
    end else if (state_q == ST_XFER && rx_valid) begin
      window_q   <= {window_q[14:0], rx_bit};
      byte_q     <= {byte_q[5:0], rx_bit};
      data_idx_q <= data_idx_q + 1'b1;
    end
  end

  // image RAM write port (clear or load)
  always_comb begin
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    if (state_q == ST_CLEAR && int'(clr_idx_q) < IMAGE_BYTES) begin
      we    = 1'b1;
      waddr = AW'(clr_idx_q);
    end else if (pay_bit && data_idx_q[2:0] == 3'd7) begin
      we    = 1'b1;
      waddr = data_idx_q[AW+2:3];
      wdata = {byte_q, rx_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end

  // configuration sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_CLEAR;
      clr_idx_q      <= '0;
      init_drive_low <= 1'b1;
      done           <= 1'b0;
      spi_cs_n       <= 1'b1;
      spi_sclk_oe    <= 1'b0;
      spi_mosi_oe    <= 1'b0;
      fast_q         <= 1'b0;
      start_q        <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (hold) begin
        state_q        <= ST_HOLD;
        done           <= 1'b0;
        spi_cs_n       <= 1'b1;
        spi_sclk_oe    <= 1'b0;
        spi_mosi_oe    <= 1'b0;
        init_drive_low <= 1'b1;
      end else begin
        unique case (state_q)
          ST_HOLD: begin
            state_q   <= ST_CLEAR;
            clr_idx_q <= '0;
          end
          ST_CLEAR: begin
            clr_idx_q <= clr_idx_q + 1'b1;
            if (clr_idx_q == CW'(CLR_LAST)) begin
              state_q        <= ST_WAIT;
              init_drive_low <= 1'b0;
            end
          end
          ST_WAIT: begin
            if (init_s) begin
              fast_q      <= (mode_sel == MODE_FAST);
              start_q     <= 1'b1;
              spi_cs_n    <= 1'b0;
              spi_sclk_oe <= 1'b1;
              spi_mosi_oe <= 1'b1;
              state_q     <= ST_XFER;
            end
          end
          ST_XFER: begin
            if (fin) begin
              spi_cs_n    <= 1'b1;
              spi_sclk_oe <= 1'b0;
              spi_mosi_oe <= 1'b0;
              if (crc_ok) begin
                done    <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                init_drive_low <= 1'b1;
                state_q        <= ST_FAIL;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $rose(spi_cs_n));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (spi_cs_n && !spi_sclk_oe && !spi_mosi_oe));

  // R8
  done_init_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !init_drive_low);

  // R2
  cs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> $past(init_s));

  // R10
  hold_effect_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!done && spi_cs_n && init_drive_low));

endmodule

// File: tb/cfg_flash_loader_tb_top.sv
module cfg_flash_loader_tb_top;

  localparam int          DEPTH = 8;
  localparam int          HALF  = 2;
  localparam logic [23:0] ADDR  = 24'hA5C30F;
  localparam int          CLR_N = (DEPTH < 4) ? 4 : DEPTH;
  localparam int          WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       prog_n;
  logic       init_hold;
  logic       init_in;
  logic [2:0] mode_sel;
  logic       spi_miso;
  logic       spi_cs_n, spi_sclk, spi_sclk_oe, spi_mosi, spi_mosi_oe;
  logic       init_drive_low, done;
  logic [$clog2(DEPTH)-1:0] rd_addr;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  assign init_in = ~init_drive_low & ~init_hold;

  cfg_flash_loader #(
    .CLK_PERIOD_NS(20), .PROG_MIN_NS(500), .SCK_HALF_CYC(HALF),
    .IMAGE_BYTES(DEPTH), .START_ADDR(ADDR)
  ) dut_i (
    .clk(clk), .rst(rst), .prog_n(prog_n), .init_in(init_in), .mode_sel(mode_sel),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_sclk_oe(spi_sclk_oe), .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe),
    .init_drive_low(init_drive_low), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // ---------------- flash model ----------------
  logic [7:0]  img [DEPTH+2];
  logic [39:0] cmd_cap;
  logic [7:0]  opc_f;
  int          rise_cnt, out_idx;
  logic        last_cs = 1'b1, last_sclk = 1'b0;

  initial spi_miso = 1'b0;

  always @(spi_cs_n or spi_sclk) begin
    if (!spi_cs_n && last_cs) begin
      rise_cnt = 0;
      out_idx  = 0;
      cmd_cap  = '0;
      opc_f    = '0;
    end else if (!spi_cs_n && spi_sclk && !last_sclk) begin
      if (rise_cnt < 40) cmd_cap = {cmd_cap[38:0], spi_mosi};
      rise_cnt++;
      if (rise_cnt == 8) opc_f = cmd_cap[7:0];
    end else if (!spi_cs_n && !spi_sclk && last_sclk) begin
      if (rise_cnt >= ((opc_f == 8'h0B) ? 40 : 32) && out_idx < (DEPTH + 2) * 8) begin
        spi_miso = img[out_idx / 8][7 - (out_idx % 8)];
        out_idx++;
      end
    end
    last_cs   = spi_cs_n;
    last_sclk = spi_sclk;
  end

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {img[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic make_img(input int seed, input bit corrupt);
    logic [15:0] c;
    for (int i = 0; i < DEPTH; i++) img[i] = 8'((seed * 37) + (i * 91) + (i * i * 5));
    c = ref_crc(DEPTH);
    img[DEPTH]     = c[15:8] ^ (corrupt ? 8'h01 : 8'h00);
    img[DEPTH + 1] = c[7:0];
  endtask

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  bit exp_ok = 1'b1, exp_fast = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mchk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
    mon_checks++;
    if (act !== exp) begin
      mon_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock reference monitor
  int   cs_low = 0, hi_run = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (done) mchk("R9", "pins released with done",
                     {spi_cs_n, spi_sclk_oe, spi_mosi_oe}, 3'b100);
      if (!spi_cs_n) mchk("R9", "enables during read", {spi_sclk_oe, spi_mosi_oe}, 2'b11);
      if (spi_sclk && prev_sclk) mchk("R4", "mosi stable while sclk high", spi_mosi, prev_mosi);
      if (spi_sclk) hi_run++;
      if (!spi_sclk && prev_sclk) begin
        mchk("R4", "sclk high phase", hi_run, HALF);
        hi_run = 0;
      end
      if (!spi_cs_n) cs_low++;
      if (spi_cs_n && !prev_cs) begin
        mchk("R5", "cs_n low window", cs_low,
             2 * ((exp_fast ? 40 : 32) + (DEPTH + 2) * 8) * HALF + 2);
        mchk("R7", "done at cs_n rise", done, exp_ok);
        mchk("R8", "init low at cs_n rise", init_drive_low, !exp_ok);
        cs_low = 0;
      end
      prev_cs   = spi_cs_n;
      prev_sclk = spi_sclk;
      prev_mosi = spi_mosi;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
    end
  end

  task automatic wait_cs(input logic lvl, input string req);
    int n = 0;
    while (spi_cs_n !== lvl && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "cs_n reached level", spi_cs_n, lvl);
  endtask

  task automatic check_ram(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = a[$clog2(DEPTH)-1:0];
      @(negedge clk);
      chk(req, "ram byte", rd_data, img[a]);
    end
  endtask

  task automatic prog_pulse(input int len);
    prog_n = 1'b0;
    repeat (len) @(negedge clk);
    prog_n = 1'b1;
  endtask

  initial begin
    rst = 1'b1; prog_n = 1'b1; init_hold = 1'b1; mode_sel = 3'b111; rd_addr = '0;
    make_img(1, 1'b0);
    exp_ok = 1'b1; exp_fast = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "reset outputs", {init_drive_low, done, spi_cs_n, spi_sclk_oe, spi_mosi_oe},
        5'b10100);
    repeat (CLR_N - 1) @(negedge clk);
    chk("R1", "init still low in clear", init_drive_low, 1'b1);
    @(negedge clk);
    chk("R1", "init released after clear", init_drive_low, 1'b0);
    repeat (20) @(negedge clk);
    chk("R2", "no read while init held", spi_cs_n, 1'b1);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = a[$clog2(DEPTH)-1:0];
      @(negedge clk);
      chk("R6", "ram cleared", rd_data, 8'h00);
    end
    init_hold = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "cs_n high two edges after init high", spi_cs_n, 1'b1);
    @(negedge clk);
    chk("R2", "cs_n low on third edge", spi_cs_n, 1'b0);
    wait_cs(1'b1, "R5");
    chk("R7", "done after good load", done, 1'b1);
    chk("R3", "plain read command", cmd_cap, {8'h03, ADDR, 8'h00});
    check_ram("R6");

    // short program pulse is ignored
    prog_pulse(10);
    repeat (50) @(negedge clk);
    chk("R10", "short pulse ignored", {done, spi_cs_n, init_drive_low}, 3'b110);

    // long pulse, fast mode
    mode_sel = 3'b110; exp_fast = 1'b1;
    prog_n = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10", "held program state", {done, spi_cs_n, init_drive_low}, 3'b011);
    make_img(2, 1'b0);
    prog_n = 1'b1;
    wait_cs(1'b0, "R10");
    wait_cs(1'b1, "R5");
    chk("R7", "done after fast load", done, 1'b1);
    chk("R3", "fast read command", cmd_cap, {8'h0B, ADDR, 8'h00});
    check_ram("R6");

    // corrupted checksum
    mode_sel = 3'b111; exp_fast = 1'b0; exp_ok = 1'b0;
    make_img(3, 1'b1);
    prog_pulse(40);
    wait_cs(1'b0, "R10");
    wait_cs(1'b1, "R5");
    chk("R8", "failure flags", {done, init_drive_low}, 2'b01);
    repeat (50) @(negedge clk);
    chk("R8", "failure persists", {done, init_drive_low}, 2'b01);
    chk("R9", "pins released after failure", {spi_cs_n, spi_sclk_oe, spi_mosi_oe}, 3'b100);

    // recovery
    exp_ok = 1'b1;
    make_img(4, 1'b0);
    prog_pulse(40);
    wait_cs(1'b0, "R10");
    wait_cs(1'b1, "R5");
    chk("R10", "reload after failure", {done, init_drive_low}, 2'b10);
    check_ram("R6");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks + mon_checks, fails + mon_fails);
    $finish;
  end

endmodule